// File: doc/BRIEF.md
# Peripheral interrupt mask and polarity forwarder

This block takes a configurable number of interrupt request lines from on-chip peripherals and drives one output line per source toward a parent interrupt controller. Output line n always belongs to input source n, so the parent can map the whole group with one fixed base offset. Each source has a mask bit and a polarity bit. The polarity bit is XOR-ed with the raw line to give a conditioned, active-high signal.

A compile-time parameter picks one of two variants. The pass-through variant forwards the conditioned level with no storage. The latched variant records a pending bit on each rising edge of the conditioned signal. The pending bit is set whether or not the source is masked. Software clears it by writing 1 to the status bank. In both variants the mask bit gates only the output.

Software reaches the three banks over a small 16-bit register bus with byte addresses. Sixteen sources share each register, and registers within a bank sit 4 bytes apart.

Top module: `irq_fwd`

## Requirements
- R1: Source n sits at bit n mod 16 of register n>>4, at byte address bank base + 4*(n>>4). The mask bank base is 0x00, the polarity bank base is 0x10 and the status bank base is 0x20. An address with bit 1 or bit 0 set, with bits [5:4] equal to 3, or with any bit at position 6 or above set, selects no register: a read returns 0 and a write changes nothing.
- R2: After reset every mask bit is 1, every polarity bit is 0, every pending bit is 0, every output is 0 and bus_rdata is 0.
- R3: A mask bit of 1 holds that source's output at 0. A mask bit of 0 lets the source through.
- R4: The conditioned signal is the raw input XOR the polarity bit. Polarity 0 means active high and polarity 1 means active low.
- R5: In the pass-through variant (LATCHED=0), each output equals conditioned AND NOT mask in the same cycle, with no register on the path. A status read returns the live conditioned levels, and a status write has no effect.
- R6: In the latched variant (LATCHED=1), a pending bit is set on every 0-to-1 transition of the conditioned signal, even while the source is masked. Each output equals pending AND NOT mask, and a status read returns the raw pending bits.
- R7: In the latched variant, writing 1 to a status bit clears that pending bit, and writing 0 leaves it unchanged.
- R8: In the latched variant, when a new rising edge and a write of 1 to clear reach the same bit in the same cycle, the bit ends up set.
- R9: bus_rdata is loaded on the clock edge that samples bus_rd and keeps its value at all other times. Mask and polarity reads return the values last written. Writes take effect on the edge that samples bus_wr.
- R10: Bits and registers for source numbers at or above NSRC read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NSRC | Raw interrupt lines from the peripherals |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| irq_out | output | NSRC | Forwarded interrupt lines, one per source |

## Verification
The bench builds the block twice with NSRC=20, once with LATCHED=1 and once with LATCHED=0, and drives both from the same inputs and bus. Twenty sources fill one full register and part of a second. This exercises the register-index and bit-position split, the partly populated register and the fully empty registers of each bank. It also keeps the per-source sweep over both polarities short enough to run in full. A reference model in the bench tracks the expected mask, polarity and pending state, and every output and read-back is compared against it.

// File: rtl/irq_fwd.sv
module irq_fwd #(
  parameter int NSRC    = 20,
  parameter bit LATCHED = 1'b1,
  parameter int AW      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_irq,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic [NSRC-1:0] irq_out
);
  localparam int NREG = (NSRC + 15) / 16;

  logic [NSRC-1:0] mask_q, pol_q, adj, stat_v, wbits, lane;
  logic [1:0]      bank, idx;
  logic            hit, wr_mask, wr_pol, wr_stat;
  logic [15:0]     rword;

  assign bank    = bus_addr[5:4];
  assign idx     = bus_addr[3:2];
  assign hit     = ((bus_addr >> 6) == '0) && (bus_addr[1:0] == 2'b00) && (bank != 2'd3);
  assign wr_mask = bus_wr && hit && (bank == 2'd0);
  assign wr_pol  = bus_wr && hit && (bank == 2'd1);
  assign wr_stat = bus_wr && hit && (bank == 2'd2);

  for (genvar n = 0; n < NSRC; n++) begin : g_lane
    assign lane[n]  = (idx == 2'(n / 16));
    assign wbits[n] = lane[n] & bus_wdata[n % 16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pol_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= (mask_q & ~lane) | wbits;
      if (wr_pol)  pol_q  <= (pol_q & ~lane) | wbits;
    end
  end

  assign adj = src_irq ^ pol_q;

  if (LATCHED) begin : g_latched
    logic [NSRC-1:0] adj_q, pend_q, edge_v, clr;
    assign edge_v = adj & ~adj_q;
    assign clr    = wr_stat ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        adj_q  <= '0;
        pend_q <= '0;
      end else begin
        adj_q  <= adj;
        pend_q <= (pend_q & ~clr) | edge_v;
      end
    end

    assign stat_v  = pend_q;
    assign irq_out = pend_q & ~mask_q;

    p_pend_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~$past(pend_q) & ~$past(edge_v)) == '0);
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~edge_v) != '0) |=> ((pend_q & $past(clr & ~edge_v)) == '0));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v != '0) |=> ((pend_q & $past(edge_v)) == $past(edge_v)));
  end else begin : g_pass
    assign stat_v  = adj;
    assign irq_out = adj & ~mask_q;

    p_live_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(src_irq) && $stable(mask_q) && $stable(pol_q)) |-> $stable(irq_out));
  end

  always_comb begin
    rword = '0;
    for (int b = 0; b < 16; b++) begin
      if ((int'(idx) * 16 + b) < NSRC && int'(idx) < NREG) begin
        case (bank)
          2'd0:    rword[b] = mask_q[int'(idx) * 16 + b];
          2'd1:    rword[b] = pol_q[int'(idx) * 16 + b];
          2'd2:    rword[b] = stat_v[int'(idx) * 16 + b];
          default: rword[b] = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit ? rword : 16'h0000;
  end

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_fwd_bench.sv
module irq_fwd_bench;
  localparam int NS = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [7:0]    addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata_l, rdata_p;
  logic [NS-1:0] out_l, out_p;

  irq_fwd #(.NSRC(NS), .LATCHED(1'b1), .AW(8)) u_irq_fwd (
    .clk(clk), .rst_n(rst_n), .src_irq(src), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata_l), .irq_out(out_l));
  irq_fwd #(.NSRC(NS), .LATCHED(1'b0), .AW(8)) u_irq_fwd_pt (
    .clk(clk), .rst_n(rst_n), .src_irq(src), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata_p), .irq_out(out_p));

  int total = 0, bad = 0;
  logic [NS-1:0] mask_m, pol_m, pend_m, adjq_m;

  function automatic bit hit_f(logic [7:0] a);
    return a[7:6] == 2'b00 && a[1:0] == 2'b00 && a[5:4] != 2'd3;
  endfunction

  function automatic logic [NS-1:0] lane_f(logic [7:0] a);
    logic [NS-1:0] v;
    for (int n = 0; n < NS; n++) v[n] = (n / 16) == int'(a[3:2]);
    return v;
  endfunction

  function automatic logic [NS-1:0] bits_f(logic [7:0] a, logic [15:0] d);
    logic [NS-1:0] v;
    for (int n = 0; n < NS; n++) v[n] = ((n / 16) == int'(a[3:2])) && d[n % 16];
    return v;
  endfunction

  function automatic logic [15:0] word_f(logic [NS-1:0] v, logic [7:0] a);
    logic [15:0] w = '0;
    for (int b = 0; b < 16; b++)
      if (int'(a[3:2]) * 16 + b < NS) w[b] = v[int'(a[3:2]) * 16 + b];
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_m <= '1; pol_m <= '0; pend_m <= '0; adjq_m <= '0;
    end else begin
      logic [NS-1:0] clr;
      clr = (wr && hit_f(addr) && addr[5:4] == 2'd2) ? bits_f(addr, wdata) : '0;
      pend_m <= (pend_m & ~clr) | ((src ^ pol_m) & ~adjq_m);
      adjq_m <= src ^ pol_m;
      if (wr && hit_f(addr) && addr[5:4] == 2'd0) mask_m <= (mask_m & ~lane_f(addr)) | bits_f(addr, wdata);
      if (wr && hit_f(addr) && addr[5:4] == 2'd1) pol_m <= (pol_m & ~lane_f(addr)) | bits_f(addr, wdata);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag);
    #1;
    chk({tag, " latched out"}, 32'(out_l), 32'(pend_m & ~mask_m));
    chk({tag, " pass out"}, 32'(out_p), 32'((src ^ pol_m) & ~mask_m));
  endtask

  task automatic step(string tag);
    @(negedge clk);
    chk_out(tag);
  endtask

  task automatic wreg(logic [7:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [7:0] a, string tag);
    logic [15:0] el, ep;
    @(negedge clk); addr = a; rd = 1'b1;
    if (!hit_f(a)) begin el = '0; ep = '0; end
    else case (a[5:4])
      2'd0: begin el = word_f(mask_m, a); ep = el; end
      2'd1: begin el = word_f(pol_m, a); ep = el; end
      default: begin el = word_f(pend_m, a); ep = word_f(src ^ pol_m, a); end
    endcase
    @(negedge clk); rd = 1'b0;
    chk({tag, " latched rd"}, 32'(rdata_l), 32'(el));
    chk({tag, " pass rd"}, 32'(rdata_p), 32'(ep));
  endtask

  task automatic wvec(logic [7:0] base, logic [NS-1:0] v);
    wreg(base, v[15:0]);
    wreg(base + 8'h04, 16'(v[NS-1:16]));
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_B00C;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_out("R2 reset");
    for (int a = 0; a < 12; a++) rreg(8'(a * 4), "R2 R10 reset map");
    rreg(8'h30, "R1 bank3");
    rreg(8'h40, "R1 high addr");
    rreg(8'h02, "R1 unaligned");

    // R3 R4 R6 R7: every source, both polarities, masked only elsewhere
    for (int n = 0; n < NS; n++) begin
      for (int p = 0; p < 2; p++) begin
        src = '0;
        wvec(8'h10, p ? (NS'(1) << n) : '0);
        wvec(8'h00, ~(NS'(1) << n));
        wvec(8'h20, '1);
        step("R4 idle");
        src = NS'(1) << n; step("R3 R4 assert"); step("R6 edge");
        rreg(8'(4 * (n / 16)) + 8'h20, "R6 status");
        src = '0; step("R4 release"); step("R6 edge2");
        wreg(8'(4 * (n / 16)) + 8'h20, 16'h0000);
        chk_out("R7 zero write");
        wreg(8'(4 * (n / 16)) + 8'h20, 16'(1) << (n % 16));
        chk_out("R7 clear");
        rreg(8'(4 * (n / 16)) + 8'h10, "R9 pol readback");
      end
    end

    // R6: pending while masked
    wvec(8'h10, '0); wvec(8'h00, '1); src = '0; wvec(8'h20, '1);
    src = 20'h5_A5A5; step("R6 masked edge"); step("R6 masked");
    rreg(8'h20, "R6 masked status lo"); rreg(8'h24, "R6 masked status hi");
    wvec(8'h00, '0); chk_out("R3 unmask shows pending");

    // R8: edge and clear on the same bit in the same cycle
    src = '0; wvec(8'h20, '1); step("R8 prep");
    @(negedge clk); src[3] = 1'b1; src[5] = 1'b0; addr = 8'h20; wdata = 16'hFFFF; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk_out("R8 set wins");
    rreg(8'h20, "R8 status");

    // R10 and R1: writes outside the populated map
    wreg(8'h04, 16'h0000); wreg(8'h04, 16'hFFFF); rreg(8'h04, "R10 partial reg");
    wreg(8'h0C, 16'hFFFF); wreg(8'h34, 16'hFFFF); wreg(8'h44, 16'hFFFF); wreg(8'h01, 16'h0000);
    rreg(8'h00, "R1 R10 ignored lo"); rreg(8'h0C, "R10 empty reg");

    // R9: read data holds between reads
    rreg(8'h00, "R9 read");
    held = rdata_l;
    wreg(8'h00, 16'h1234); step("R9 idle");
    chk("R9 hold", 32'(rdata_l), 32'(held));
    rreg(8'h00, "R9 readback");

    // R5 R6: pseudo-random mixes of sources, masks and polarities
    for (int k = 0; k < 64; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (k % 8 == 0) wvec(8'h10, NS'(lf >> 5));
      if (k % 4 == 0) wvec(8'h00, NS'(lf >> 9));
      if (k % 16 == 5) wvec(8'h20, NS'(lf >> 3));
      src = NS'(lf);
      step("R5 R6 mix");
      if (k % 4 == 1) begin
        rreg(8'h20, "R5 R6 mix status lo");
        rreg(8'h24, "R5 R6 mix status hi");
      end
    end
    finish_run();
  end
endmodule